// File: doc/BRIEF.md
# Synthesizer Channel Register Controller

This block is the programming front end of a fractional-N frequency synthesizer. Software shifts 24-bit words in over a three-wire serial port made of a serial clock, a data line and a load strobe. The three low bits of each word choose a register. Address 0 is the channel register, which carries the integer and fractional divider values. Addresses 1 to 3 are auxiliary registers. They hold the fractional modulus, the normal charge-pump current code, and the four fast-lock timeout counts.

The auxiliary registers are double buffered. Writing them changes nothing at the outputs. A later channel write that passes validation commits all of them at once, together with the new divider values. The commit lands on a reference clock edge. At that moment a fast-lock sequence starts: the charge-pump current code is forced to its maximum, and three loop-filter switch controls close. Each of these four outputs is released by its own timeout counter, which counts reference cycles. When the current timeout ends, the charge-pump code returns to the committed normal code. A channel write that fails validation changes nothing and raises an error flag.

Top module: `fl_chan_ctrl`

## Requirements
- R1: A word is 24 bits, shifted most significant bit first on rising edges of `ser_clk`. It is taken as complete on the rising edge of `ser_le`. Bits [2:0] of the word are the register address.
- R2: A channel word (address 0) places the integer value in bits [22:15] and the fractional value in bits [14:3]. When accepted, these values appear on `int_val` and `frac_val`.
- R3: Outputs take their new values at the fourth rising `clk` edge after `ser_le` goes high, counting from the first edge at which the high level is set up. With the default two-stage synchronizer they do not change before that edge.
- R4: A channel word is rejected if any of these holds: bit 23 is 1, the integer value is below 26, or the fractional value is not below the staged modulus. A rejected word leaves every output unchanged and sets `word_err`. An accepted channel word clears `word_err`. Accepted values always satisfy `frac_val` below the committed modulus and `int_val` of at least 26.
- R5: The auxiliary registers are staged and have no effect on any output until the next accepted channel word. Their layouts are:
  - Address 1: modulus in bits [14:3] and normal charge-pump code in bits [18:15].
  - Address 2: charge-pump timeout in bits [12:3] and switch 0 timeout in bits [22:13].
  - Address 3: switch 1 timeout in bits [12:3] and switch 2 timeout in bits [22:13].
- R6: Words with addresses 4 to 7 are ignored. They change neither the outputs nor any staged value.
- R7: From the edge at which an accepted channel word is applied, `cp_code` is 15 for exactly the staged charge-pump timeout count of cycles. After that it equals the committed normal code.
- R8: From the same edge, each `sw_close[k]` is 1 for exactly its staged timeout count of cycles and then returns to 0. A count of zero keeps that switch open.
- R9: An accepted channel word that arrives while any fast-lock output is still active restarts all four counters from their full staged counts.
- R10: After reset the outputs are as follows:
  - `int_val` is 26 and `frac_val` is 0.
  - `cp_code` is 0 and `sw_close` is 0.
  - `word_err` is 0.
  - The staged modulus is 4095 and all staged timeouts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector reference clock |
| rst_n | input | 1 | Active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_le | input | 1 | Load strobe; rising edge latches the word |
| int_val | output | 8 | Committed integer divider value |
| frac_val | output | 12 | Committed fractional value |
| cp_code | output | 4 | Charge-pump current code |
| sw_close | output | 3 | Loop-filter switch closures |
| word_err | output | 1 | Last channel word was rejected |

## Verification
Every result of a channel write is due at the fourth reference edge after the load strobe is raised on a falling edge. The bench samples at the falling edge after the third reference edge to confirm the old values are still present. It samples again after the fourth edge to see the new values, the error flag and the first fast-lock cycle. From that same falling edge, it counts on every following falling edge how many samples show maximum current and each switch closed. It compares those counts with the staged timeouts held in its own model. Restart is checked by committing a second channel word while long timeouts are still running and expecting the full counts again.

// File: rtl/fl_chan_pkg.sv
package fl_chan_pkg;
   localparam int WORD_W   = 24;
   localparam int ADDR_W   = 3;
   localparam int INT_W    = 8;
   localparam int FRAC_W   = 12;
   localparam int CP_W     = 4;
   localparam int TMR_W    = 10;
   localparam int NUM_SW   = 3;
   // field positions inside a serial word
   localparam int FRAC_LSB = ADDR_W;
   localparam int INT_LSB  = FRAC_LSB + FRAC_W;
   localparam int RSV_BIT  = INT_LSB + INT_W;
   localparam int MOD_LSB  = ADDR_W;
   localparam int CPN_LSB  = MOD_LSB + FRAC_W;
   localparam int TLO_LSB  = ADDR_W;
   localparam int THI_LSB  = TLO_LSB + TMR_W;

   typedef enum logic [ADDR_W-1:0] {
      SEL_CHAN = 3'd0,
      SEL_LOOP = 3'd1,
      SEL_TMA  = 3'd2,
      SEL_TMB  = 3'd3
   } sel_e;

   typedef logic [TMR_W-1:0] tmo_t;
endpackage

// File: rtl/fl_serial_rx.sv
module fl_serial_rx
   import fl_chan_pkg::*;
#(
   parameter int SYNC_N = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_data,
   input  logic              ser_le,
   output logic [WORD_W-1:0] word,
   output logic              word_vld
);
   logic [SYNC_N-1:0] sck_q, sdt_q, sle_q;
   logic              sck_d, sle_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sck_q <= '0;
         sdt_q <= '0;
         sle_q <= '0;
         sck_d <= 1'b0;
         sle_d <= 1'b0;
         word  <= '0;
      end else begin
         sck_q <= {sck_q[SYNC_N-2:0], ser_clk};
         sdt_q <= {sdt_q[SYNC_N-2:0], ser_data};
         sle_q <= {sle_q[SYNC_N-2:0], ser_le};
         sck_d <= sck_q[SYNC_N-1];
         sle_d <= sle_q[SYNC_N-1];
         if (sck_q[SYNC_N-1] && !sck_d)
            word <= {word[WORD_W-2:0], sdt_q[SYNC_N-1]};
      end
   end

   assign word_vld = sle_q[SYNC_N-1] & ~sle_d;
endmodule

// File: rtl/fl_reg_bank.sv
module fl_reg_bank
   import fl_chan_pkg::*;
#(
   parameter int                INT_MIN = 26,
   parameter logic [FRAC_W-1:0] MOD_RST = 12'd4095,
   parameter logic [CP_W-1:0]   CP_RST  = 4'd0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word,
   input  logic              word_vld,
   output logic [INT_W-1:0]  int_act,
   output logic [FRAC_W-1:0] frac_act,
   output logic [FRAC_W-1:0] mod_act,
   output logic [CP_W-1:0]   cpn_act,
   output logic              word_err,
   output logic              commit,
   output tmo_t              tmo_cp,
   output tmo_t [NUM_SW-1:0] tmo_sw
);
   localparam logic [INT_W-1:0] INT_LO = INT_W'(INT_MIN);

   sel_e              sel;
   logic [INT_W-1:0]  w_int;
   logic [FRAC_W-1:0] w_frac;
   logic              chan_ok;

   logic [FRAC_W-1:0] sh_mod;
   logic [CP_W-1:0]   sh_cpn;
   tmo_t              sh_tcp;
   tmo_t [NUM_SW-1:0] sh_tsw;

   logic              pend_vld, pend_ok;
   logic [INT_W-1:0]  pend_int;
   logic [FRAC_W-1:0] pend_frac;

   assign sel     = sel_e'(word[ADDR_W-1:0]);
   assign w_int   = word[INT_LSB +: INT_W];
   assign w_frac  = word[FRAC_LSB +: FRAC_W];
   assign chan_ok = !word[RSV_BIT] && (w_int >= INT_LO) && (w_frac < sh_mod);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_mod    <= MOD_RST;
         sh_cpn    <= CP_RST;
         sh_tcp    <= '0;
         sh_tsw    <= '0;
         pend_vld  <= 1'b0;
         pend_ok   <= 1'b0;
         pend_int  <= INT_LO;
         pend_frac <= '0;
         int_act   <= INT_LO;
         frac_act  <= '0;
         mod_act   <= MOD_RST;
         cpn_act   <= CP_RST;
         word_err  <= 1'b0;
      end else begin
         pend_vld <= 1'b0;
         if (word_vld) begin
            unique case (sel)
               SEL_CHAN: begin
                  pend_vld  <= 1'b1;
                  pend_ok   <= chan_ok;
                  pend_int  <= w_int;
                  pend_frac <= w_frac;
               end
               SEL_LOOP: begin
                  sh_mod <= word[MOD_LSB +: FRAC_W];
                  sh_cpn <= word[CPN_LSB +: CP_W];
               end
               SEL_TMA: begin
                  sh_tcp    <= word[TLO_LSB +: TMR_W];
                  sh_tsw[0] <= word[THI_LSB +: TMR_W];
               end
               SEL_TMB: begin
                  sh_tsw[1] <= word[TLO_LSB +: TMR_W];
                  sh_tsw[2] <= word[THI_LSB +: TMR_W];
               end
               default: ;
            endcase
         end
         // second stage: apply on the following reference edge
         if (pend_vld) begin
            word_err <= ~pend_ok;
            if (pend_ok) begin
               int_act  <= pend_int;
               frac_act <= pend_frac;
               mod_act  <= sh_mod;
               cpn_act  <= sh_cpn;
            end
         end
      end
   end

   assign commit = pend_vld & pend_ok;
   assign tmo_cp = sh_tcp;
   assign tmo_sw = sh_tsw;
endmodule

// File: rtl/fl_hold_timer.sv
module fl_hold_timer #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] count,
   output logic         active
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= count;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign active = (cnt_q != '0);
endmodule

// File: rtl/fl_chan_ctrl.sv
module fl_chan_ctrl
   import fl_chan_pkg::*;
#(
   parameter int                SYNC_N  = 2,
   parameter int                INT_MIN = 26,
   parameter logic [FRAC_W-1:0] MOD_RST = 12'd4095,
   parameter logic [CP_W-1:0]   CP_RST  = 4'd0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_data,
   input  logic              ser_le,
   output logic [INT_W-1:0]  int_val,
   output logic [FRAC_W-1:0] frac_val,
   output logic [CP_W-1:0]   cp_code,
   output logic [NUM_SW-1:0] sw_close,
   output logic              word_err
);
   localparam logic [CP_W-1:0] CP_MAX = {CP_W{1'b1}};

   if (SYNC_N < 2) begin : g_bad_sync
      $error("SYNC_N must be at least 2");
   end
   if (INT_MIN < 1 || INT_MIN >= (1 << INT_W)) begin : g_bad_int
      $error("INT_MIN out of integer field range");
   end
   if (MOD_RST == '0) begin : g_bad_mod
      $error("MOD_RST must be nonzero");
   end

   logic [WORD_W-1:0] word;
   logic              word_vld;
   logic [FRAC_W-1:0] mod_act;
   logic [CP_W-1:0]   cpn_act;
   logic              commit;
   tmo_t              tmo_cp;
   tmo_t [NUM_SW-1:0] tmo_sw;
   logic              cp_hold;

   fl_serial_rx #(.SYNC_N(SYNC_N)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .ser_clk  (ser_clk),
      .ser_data (ser_data),
      .ser_le   (ser_le),
      .word     (word),
      .word_vld (word_vld)
   );

   fl_reg_bank #(
      .INT_MIN (INT_MIN),
      .MOD_RST (MOD_RST),
      .CP_RST  (CP_RST)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .word     (word),
      .word_vld (word_vld),
      .int_act  (int_val),
      .frac_act (frac_val),
      .mod_act  (mod_act),
      .cpn_act  (cpn_act),
      .word_err (word_err),
      .commit   (commit),
      .tmo_cp   (tmo_cp),
      .tmo_sw   (tmo_sw)
   );

   fl_hold_timer #(.W(TMR_W)) u_cp_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (commit),
      .count  (tmo_cp),
      .active (cp_hold)
   );

   for (genvar k = 0; k < NUM_SW; k++) begin : g_sw
      fl_hold_timer #(.W(TMR_W)) u_sw_tmr (
         .clk    (clk),
         .rst_n  (rst_n),
         .load   (commit),
         .count  (tmo_sw[k]),
         .active (sw_close[k])
      );
   end

   assign cp_code = cp_hold ? CP_MAX : cpn_act;
endmodule

// File: rtl/fl_chan_ctrl_chk.sv
module fl_chan_ctrl_chk
   import fl_chan_pkg::*;
#(
   parameter int INT_MIN = 26
) (
   input logic              clk,
   input logic              rst_n,
   input logic [INT_W-1:0]  int_val,
   input logic [FRAC_W-1:0] frac_val,
   input logic [NUM_SW-1:0] sw_close,
   input logic              word_err,
   input logic              commit,
   input logic [FRAC_W-1:0] mod_act
);
   localparam logic [INT_W-1:0] INT_LO = INT_W'(INT_MIN);

   // R4
   frac_below_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frac_val < mod_act);

   // R4
   int_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_val >= INT_LO);

   // R3
   int_moves_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(int_val) || !$stable(frac_val)) |-> $past(commit));

   // R4
   reject_keeps_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(word_err) |-> ($stable(int_val) && $stable(frac_val)));

   for (genvar k = 0; k < NUM_SW; k++) begin : g_sw
      // R8
      sw_close_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(sw_close[k]) |-> $past(commit));
   end
endmodule

bind fl_chan_ctrl fl_chan_ctrl_chk #(.INT_MIN(INT_MIN)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .int_val  (int_val),
   .frac_val (frac_val),
   .sw_close (sw_close),
   .word_err (word_err),
   .commit   (commit),
   .mod_act  (mod_act)
);

// File: tb/tb_fl_chan_ctrl.sv
`timescale 1ns/1ps
module tb_fl_chan_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_clk = 1'b0;
   logic       ser_data = 1'b0;
   logic       ser_le = 1'b0;
   logic [7:0] int_val;
   logic [11:0] frac_val;
   logic [3:0] cp_code;
   logic [2:0] sw_close;
   logic       word_err;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // bench model
   int e_int = 26, e_frac = 0, e_cpn = 0;
   bit e_err = 1'b0;
   int s_mod = 4095, s_cpn = 0, s_tcp = 0;
   int s_tsw [3] = '{0, 0, 0};

   always #2 clk = ~clk;

   fl_chan_ctrl dut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_le(ser_le), .int_val(int_val), .frac_val(frac_val),
      .cp_code(cp_code), .sw_close(sw_close), .word_err(word_err)
   );

   task automatic chk(input bit c, input string req, input int act, input int exp);
      n_chk++;
      if (!c) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [23:0] w_chan(input bit rsv, input int iv, input int fv);
      return {rsv, 8'(iv), 12'(fv), 3'd0};
   endfunction
   function automatic logic [23:0] w_loop(input int md, input int cpn);
      return {5'd0, 4'(cpn), 12'(md), 3'd1};
   endfunction
   function automatic logic [23:0] w_tma(input int tcp, input int t0);
      return {1'b0, 10'(t0), 10'(tcp), 3'd2};
   endfunction
   function automatic logic [23:0] w_tmb(input int t1, input int t2);
      return {1'b0, 10'(t2), 10'(t1), 3'd3};
   endfunction
   function automatic bit chan_valid(input logic [23:0] w);
      return !w[23] && (int'(w[22:15]) >= 26) && (int'(w[14:3]) < s_mod);
   endfunction

   // R1: shift most significant bit first on serial clock rising edges
   task automatic send_bits(input logic [23:0] w);
      for (int b = 23; b >= 0; b--) begin
         ser_data = w[b];
         repeat (2) @(negedge clk);
         ser_clk = 1'b1;
         repeat (2) @(negedge clk);
         ser_clk = 1'b0;
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic wr_aux(input logic [23:0] w);
      send_bits(w);
      ser_le = 1'b1;
      repeat (6) @(negedge clk);
      ser_le = 1'b0;
      repeat (2) @(negedge clk);
      case (w[2:0])
         3'd1: begin s_mod = int'(w[14:3]); s_cpn = int'(w[18:15]); end
         3'd2: begin s_tcp = int'(w[12:3]); s_tsw[0] = int'(w[22:13]); end
         3'd3: begin s_tsw[1] = int'(w[12:3]); s_tsw[2] = int'(w[22:13]); end
         default: ;
      endcase
   endtask

   task automatic check_idle_outputs(input string req);
      chk(int'(int_val) == e_int, req, int'(int_val), e_int);
      chk(int'(frac_val) == e_frac, req, int'(frac_val), e_frac);
      chk(int'(cp_code) == e_cpn, req, int'(cp_code), e_cpn);
      chk(sw_close == 3'b000, req, int'(sw_close), 0);
      chk(word_err == e_err, req, int'(word_err), int'(e_err));
   endtask

   // count fast-lock samples starting at the falling edge just after commit
   task automatic measure_fl();
      int c_cp = 0;
      int c_sw [3] = '{0, 0, 0};
      int lim = s_tcp;
      for (int k = 0; k < 3; k++) if (s_tsw[k] > lim) lim = s_tsw[k];
      lim = lim + 4;
      for (int i = 0; i < lim; i++) begin
         if (cp_code == 4'hF) c_cp++;
         for (int k = 0; k < 3; k++) if (sw_close[k]) c_sw[k]++;
         @(negedge clk);
      end
      chk(c_cp == s_tcp, "R7 max current cycles", c_cp, s_tcp);
      chk(int'(cp_code) == e_cpn, "R7 normal code after timeout", int'(cp_code), e_cpn);
      for (int k = 0; k < 3; k++)
         chk(c_sw[k] == s_tsw[k], "R8 switch closed cycles", c_sw[k], s_tsw[k]);
      chk(sw_close == 3'b000, "R8 switches open after timeout", int'(sw_close), 0);
   endtask

   task automatic apply_chan(input logic [23:0] w, input bit measure);
      bit ok = chan_valid(w);
      send_bits(w);
      ser_le = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R3: not yet applied after the third edge
      chk(int'(int_val) == e_int, "R3 int held before update edge", int'(int_val), e_int);
      chk(int'(frac_val) == e_frac, "R3 frac held before update edge", int'(frac_val), e_frac);
      @(posedge clk);
      @(negedge clk);
      ser_le = 1'b0;
      if (ok) begin
         e_int = int'(w[22:15]);
         e_frac = int'(w[14:3]);
         e_cpn = s_cpn;
         e_err = 1'b0;
      end else begin
         e_err = 1'b1;
      end
      // R1 R2: fields land on the outputs at the fourth edge
      chk(int'(int_val) == e_int, "R2 int value", int'(int_val), e_int);
      chk(int'(frac_val) == e_frac, "R2 frac value", int'(frac_val), e_frac);
      chk(word_err == e_err, "R4 error flag", int'(word_err), int'(e_err));
      if (ok && measure) begin
         measure_fl();
      end else if (!ok) begin
         chk(sw_close == 3'b000, "R4 rejected word starts no fast lock", int'(sw_close), 0);
         chk(int'(cp_code) == e_cpn, "R4 rejected word keeps current code", int'(cp_code), e_cpn);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog (all requirements) actual=200000 cycles expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h1C0DE5));
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10
      check_idle_outputs("R10 reset state");

      // R5: staged values have no visible effect
      wr_aux(w_loop(4000, 5));
      wr_aux(w_tma(20, 30));
      wr_aux(w_tmb(10, 0));
      check_idle_outputs("R5 staged aux without commit");

      // commit with frac just below the staged modulus (R4 boundary)
      apply_chan(w_chan(1'b0, 100, 3999), 1'b1);

      // R4 rejections
      apply_chan(w_chan(1'b0, 120, 4000), 1'b0);
      apply_chan(w_chan(1'b0, 25, 7), 1'b0);
      apply_chan(w_chan(1'b1, 120, 7), 1'b0);
      // accepted boundaries clear the flag
      apply_chan(w_chan(1'b0, 255, 0), 1'b1);
      apply_chan(w_chan(1'b0, 26, 1), 1'b1);

      // R6: ignored addresses
      send_bits({21'h1FFFFF, 3'd5});
      ser_le = 1'b1;
      repeat (6) @(negedge clk);
      ser_le = 1'b0;
      repeat (2) @(negedge clk);
      check_idle_outputs("R6 ignored address outputs");
      send_bits({8'h00, 12'd3, 1'b1, 3'd0, 3'd7});
      ser_le = 1'b1;
      repeat (6) @(negedge clk);
      ser_le = 1'b0;
      repeat (2) @(negedge clk);
      // R6: staged modulus 4000 and timeouts unchanged, so frac 3990 is accepted
      apply_chan(w_chan(1'b0, 77, 3990), 1'b1);

      // R9: restart during active fast lock
      wr_aux(w_loop(4000, 9));
      wr_aux(w_tma(400, 500));
      wr_aux(w_tmb(300, 1023));
      apply_chan(w_chan(1'b0, 60, 100), 1'b0);
      chk(sw_close == 3'b111, "R9 fast lock running before restart", int'(sw_close), 7);
      apply_chan(w_chan(1'b0, 61, 200), 1'b1);

      // random mix
      for (int it = 0; it < 24; it++) begin
         int sel = int'($urandom % 4);
         if (sel == 0) wr_aux(w_loop(100 + int'($urandom % 3996), int'($urandom % 15)));
         if (sel == 1) wr_aux(w_tma(int'($urandom % 41), int'($urandom % 41)));
         if (sel == 2) wr_aux(w_tmb(int'($urandom % 41), int'($urandom % 41)));
         apply_chan(w_chan(($urandom % 16) == 0, int'($urandom % 256),
                           int'($urandom % (s_mod + 8))), 1'b1);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule